// File: doc/BRIEF.md
# Multi-Slot In-Order Retire Queue

This block keeps in-flight instructions in program order inside a circular array of slots. At dispatch an instruction asks for a run of contiguous slots, one for each micro-op. The block normalizes the count, reserves the run at the tail and returns a token. The token is the index of the run's first slot. The entry stored there records an opaque tag, the run length and an executed flag, which starts cleared.

Execution units report completion by token, and that sets the entry's executed flag. When the retire stage is enabled, the block frees entries from the head in a single cycle while each one is executed. It stops at the first unexecuted entry or at the per-cycle retire limit. Each retired entry returns its whole run of slots to the free pool. The wrap arithmetic uses compare-and-subtract, so the slot count need not be a power of two.

Top module: `retire_queue`

## Requirements
- R1: After reset the free-slot count equals SLOTS, `empty` is 1, `full` is 0, `headValid` is 0 and `retCount` is 0.
- R2: A request's micro-op count is clamped to at most SLOTS and then raised to at least 1. An accepted reservation lowers `freeSlots` by that normalized count.
- R3: `rsvToken` is the tail index before the reservation. The tail advances by the normalized count modulo SLOTS, so the next token is (token + count) mod SLOTS.
- R4: `rsvReady` is 1 exactly when `freeSlots` is at least the normalized count. A request presented while `rsvReady` is 0 leaves the tail and the free count unchanged.
- R5: A completion with `cmplValid` and a token below SLOTS sets that entry's executed flag. The effect is visible as `headExecuted` when that entry is at the head.
- R6: Retirement is strictly in order. An unexecuted head blocks every later executed entry, and `retCount` is then 0.
- R7: With `retireEn` high, `retCount` is the number of consecutive executed entries from the head, capped at MAX_RETIRE. A MAX_RETIRE of 0 means no cap beyond the queue contents.
- R8: Retiring an entry advances the head by its stored run length modulo SLOTS and returns that many slots to `freeSlots`, including runs that wrap past the last slot.
- R9: `full` is 1 exactly when `freeSlots` is 0, and `empty` is 1 exactly when `freeSlots` equals SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rsvValid | input | 1 | Reservation request |
| rsvUops | input | UOP_W | Requested micro-op count |
| rsvTag | input | TAG_W | Opaque tag stored with the entry |
| rsvReady | output | 1 | Enough free slots for the normalized request |
| rsvToken | output | IDX_W | Token the current request receives (tail index) |
| cmplValid | input | 1 | Completion strobe |
| cmplToken | input | IDX_W | Token of the completed entry |
| retireEn | input | 1 | Retire stage enabled this cycle |
| retCount | output | CNT_W | Entries retired at the coming edge |
| headValid | output | 1 | Queue holds at least one entry |
| headTag | output | TAG_W | Tag of the head entry |
| headExecuted | output | 1 | Head entry has completed |
| freeSlots | output | CNT_W | Unreserved slot count |
| empty | output | 1 | No slot reserved |
| full | output | 1 | No slot free |

## Verification
The checks assume that the sources are well behaved. Completion tokens always name a live entry below SLOTS, no entry completes twice, and a reservation is only counted when `rsvReady` is high. The directed stimulus completes only tokens it received from the block, each of them once. It presents one deliberately oversized request to confirm that a refused reservation leaves no trace, and it never drives an out-of-range completion.

// File: rtl/rq_pkg.sv
`timescale 1ns/1ps
package rq_pkg;
  // Write strobes from control to the entry store
  typedef struct packed {
    logic rsvWe;   // write a new entry header at the tail
    logic cmplWe;  // set executed flag at the completion index
  } rqStrobe_t;
endpackage

// File: rtl/rq_store.sv
`timescale 1ns/1ps
module rq_store
  import rq_pkg::*;
#(
  parameter int SLOTS = 12,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int IDX_W = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  rqStrobe_t                        stb,
  input  logic [IDX_W-1:0]                 rsvIdx,
  input  logic [CNT_W-1:0]                 rsvSlots,
  input  logic [TAG_W-1:0]                 rsvTag,
  input  logic [IDX_W-1:0]                 cmplIdx,
  output logic [SLOTS-1:0][CNT_W-1:0]      entSlots,
  output logic [SLOTS-1:0][TAG_W-1:0]      entTag,
  output logic [SLOTS-1:0]                 entExec
);
  // One header register set per slot; only run-leading slots are ever read
  for (genvar i = 0; i < SLOTS; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entExec[i] <= 1'b0;
      end else if (stb.rsvWe && rsvIdx == IDX_W'(i)) begin
        entExec[i] <= 1'b0;
      end else if (stb.cmplWe && cmplIdx == IDX_W'(i)) begin
        entExec[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (stb.rsvWe && rsvIdx == IDX_W'(i)) begin
        entSlots[i] <= rsvSlots;
        entTag[i]   <= rsvTag;
      end
    end
  end
endmodule

// File: rtl/rq_ctrl.sv
`timescale 1ns/1ps
module rq_ctrl
  import rq_pkg::*;
#(
  parameter int SLOTS      = 12,
  parameter int UOP_W      = 5,
  parameter int MAX_RETIRE = 2,
  parameter int CNT_W      = 4,
  parameter int IDX_W      = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rsvValid,
  input  logic [UOP_W-1:0]            rsvUops,
  input  logic                        cmplValid,
  input  logic [IDX_W-1:0]            cmplToken,
  input  logic                        retireEn,
  input  logic [SLOTS-1:0][CNT_W-1:0] entSlots,
  input  logic [SLOTS-1:0]            entExec,
  output rqStrobe_t                   stb,
  output logic [IDX_W-1:0]            tailIdx,
  output logic [CNT_W-1:0]            rsvSlots,
  output logic                        rsvReady,
  output logic [IDX_W-1:0]            headIdx,
  output logic [CNT_W-1:0]            retCount,
  output logic [CNT_W-1:0]            freeSlots
);
  localparam int LIM   = (MAX_RETIRE == 0 || MAX_RETIRE > SLOTS) ? SLOTS : MAX_RETIRE;
  localparam int SUM_W = CNT_W + 1;
  localparam int NRM_W = (UOP_W > CNT_W) ? UOP_W : CNT_W;

  logic [CNT_W-1:0] freeCnt, usedCnt, freedCnt, leftCnt;
  logic [IDX_W-1:0] nextHead;
  logic             accept;

  // Modulo add by compare-and-subtract; operands never exceed SLOTS
  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0] base,
                                               input logic [CNT_W-1:0] n);
    logic [SUM_W-1:0] s;
    s = SUM_W'(base) + SUM_W'(n);
    if (s >= SUM_W'(SLOTS)) s = s - SUM_W'(SLOTS);
    return IDX_W'(s);
  endfunction

  // Normalize request: clamp to SLOTS, then at least one slot
  always_comb begin
    if (NRM_W'(rsvUops) > NRM_W'(SLOTS)) rsvSlots = CNT_W'(SLOTS);
    else if (rsvUops == '0)              rsvSlots = CNT_W'(1);
    else                                 rsvSlots = CNT_W'(rsvUops);
  end

  assign rsvReady   = (freeCnt >= rsvSlots);
  assign accept     = rsvValid && rsvReady;
  assign usedCnt    = CNT_W'(SLOTS) - freeCnt;
  assign stb.rsvWe  = accept;
  assign stb.cmplWe = cmplValid && (SUM_W'(cmplToken) < SUM_W'(SLOTS));

  // In-order retire scan: up to LIM consecutive executed entries from head
  always_comb begin
    logic [IDX_W-1:0] ptr;
    logic             stop;
    ptr      = headIdx;
    leftCnt  = usedCnt;
    stop     = 1'b0;
    retCount = '0;
    for (int k = 0; k < LIM; k++) begin
      if (!stop && retireEn && leftCnt != '0 && entExec[ptr]) begin
        retCount = retCount + CNT_W'(1);
        leftCnt  = leftCnt - entSlots[ptr];
        ptr      = wrapAdd(ptr, entSlots[ptr]);
      end else begin
        stop = 1'b1;
      end
    end
    nextHead = ptr;
  end

  assign freedCnt = usedCnt - leftCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      freeCnt <= CNT_W'(SLOTS);
    end else begin
      headIdx <= nextHead;
      if (accept) tailIdx <= wrapAdd(tailIdx, rsvSlots);
      freeCnt <= freeCnt - (accept ? rsvSlots : '0) + freedCnt;
    end
  end

  assign freeSlots = freeCnt;
endmodule

// File: rtl/retire_queue.sv
`timescale 1ns/1ps
module retire_queue
  import rq_pkg::*;
#(
  parameter int SLOTS      = 12,
  parameter int TAG_W      = 8,
  parameter int UOP_W      = 5,
  parameter int MAX_RETIRE = 2,
  localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W     = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rsvValid,
  input  logic [UOP_W-1:0] rsvUops,
  input  logic [TAG_W-1:0] rsvTag,
  output logic             rsvReady,
  output logic [IDX_W-1:0] rsvToken,
  input  logic             cmplValid,
  input  logic [IDX_W-1:0] cmplToken,
  input  logic             retireEn,
  output logic [CNT_W-1:0] retCount,
  output logic             headValid,
  output logic [TAG_W-1:0] headTag,
  output logic             headExecuted,
  output logic [CNT_W-1:0] freeSlots,
  output logic             empty,
  output logic             full
);
  rqStrobe_t                  stb;
  logic [CNT_W-1:0]           rsvSlots;
  logic [IDX_W-1:0]           headIdx;
  logic [SLOTS-1:0][CNT_W-1:0] entSlots;
  logic [SLOTS-1:0][TAG_W-1:0] entTag;
  logic [SLOTS-1:0]           entExec;

  rq_ctrl #(.SLOTS(SLOTS), .UOP_W(UOP_W), .MAX_RETIRE(MAX_RETIRE),
            .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvUops(rsvUops),
    .cmplValid(cmplValid), .cmplToken(cmplToken), .retireEn(retireEn),
    .entSlots(entSlots), .entExec(entExec), .stb(stb), .tailIdx(rsvToken),
    .rsvSlots(rsvSlots), .rsvReady(rsvReady), .headIdx(headIdx),
    .retCount(retCount), .freeSlots(freeSlots)
  );

  rq_store #(.SLOTS(SLOTS), .TAG_W(TAG_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .rsvIdx(rsvToken), .rsvSlots(rsvSlots),
    .rsvTag(rsvTag), .cmplIdx(cmplToken), .entSlots(entSlots), .entTag(entTag),
    .entExec(entExec)
  );

  assign empty        = (freeSlots == CNT_W'(SLOTS));
  assign full         = (freeSlots == '0);
  assign headValid    = !empty;
  assign headTag      = entTag[headIdx];
  assign headExecuted = headValid && entExec[headIdx];
endmodule

// File: rtl/rq_chk.sv
`timescale 1ns/1ps
module rq_chk #(
  parameter int SLOTS      = 12,
  parameter int MAX_RETIRE = 2,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             rsvValid,
  input logic             rsvReady,
  input logic             cmplValid,
  input logic [IDX_W-1:0] cmplToken,
  input logic [CNT_W-1:0] retCount,
  input logic             headExecuted,
  input logic [CNT_W-1:0] freeSlots,
  input logic             empty
);
  // R2
  free_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeSlots <= CNT_W'(SLOTS));
  // R2
  rsv_consumes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsvValid && rsvReady && retCount == '0) |=> freeSlots < $past(freeSlots));
  // R4
  refused_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rsvValid && !rsvReady && retCount == '0) |=> $stable(freeSlots));
  // R5
  cmpl_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> (int'(cmplToken) < SLOTS));
  // R6
  in_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    !headExecuted |-> retCount == '0);
  // R7
  retire_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (MAX_RETIRE != 0) |-> (int'(retCount) <= MAX_RETIRE));
  // R8
  retire_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retCount != '0 && !(rsvValid && rsvReady)) |=> freeSlots > $past(freeSlots));
  // R1
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> retCount == '0);
endmodule

bind retire_queue rq_chk #(.SLOTS(SLOTS), .MAX_RETIRE(MAX_RETIRE),
                           .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvReady(rsvReady),
  .cmplValid(cmplValid), .cmplToken(cmplToken), .retCount(retCount),
  .headExecuted(headExecuted), .freeSlots(freeSlots), .empty(empty)
);

// File: tb/retire_queue_tb.sv
`timescale 1ns/1ps
module retire_queue_tb;
  localparam int SLOTS = 12;
  localparam int IDX_W = 4;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rsvValid = 1'b0;
  logic [4:0] rsvUops = '0;
  logic [7:0] rsvTag = '0;
  logic cmplValid = 1'b0;
  logic [IDX_W-1:0] cmplToken = '0;
  logic retireEn = 1'b0;

  logic rsvReady, headValid, headExecuted, empty, full;
  logic [IDX_W-1:0] rsvToken;
  logic [CNT_W-1:0] retCount, freeSlots;
  logic [7:0] headTag;

  logic aReady, aHeadValid, aHeadExec, aEmpty, aFull;
  logic [IDX_W-1:0] aToken;
  logic [CNT_W-1:0] aRetCount, aFree;
  logic [7:0] aHeadTag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  retire_queue #(.SLOTS(SLOTS), .TAG_W(8), .UOP_W(5), .MAX_RETIRE(2)) u_dut (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvUops(rsvUops), .rsvTag(rsvTag),
    .rsvReady(rsvReady), .rsvToken(rsvToken), .cmplValid(cmplValid),
    .cmplToken(cmplToken), .retireEn(retireEn), .retCount(retCount),
    .headValid(headValid), .headTag(headTag), .headExecuted(headExecuted),
    .freeSlots(freeSlots), .empty(empty), .full(full)
  );

  retire_queue #(.SLOTS(SLOTS), .TAG_W(8), .UOP_W(5), .MAX_RETIRE(0)) u_dutAll (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvUops(rsvUops), .rsvTag(rsvTag),
    .rsvReady(aReady), .rsvToken(aToken), .cmplValid(cmplValid),
    .cmplToken(cmplToken), .retireEn(retireEn), .retCount(aRetCount),
    .headValid(aHeadValid), .headTag(aHeadTag), .headExecuted(aHeadExec),
    .freeSlots(aFree), .empty(aEmpty), .full(aFull)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rsvValid = 0; cmplValid = 0; retireEn = 0; rsvUops = '0; rsvTag = '0;
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic doRsv(int uops, int tag, output int tok, output int rdy);
    rsvValid = 1; rsvUops = 5'(uops); rsvTag = 8'(tag);
    #2 tok = int'(rsvToken); rdy = int'(rsvReady);
    @(posedge clk); #1 rsvValid = 0;
  endtask

  task automatic doCmpl(int tok);
    cmplValid = 1; cmplToken = IDX_W'(tok);
    @(posedge clk); #1 cmplValid = 0;
  endtask

  task automatic doRetire(output int cnt, output int cntAll);
    retireEn = 1;
    #2 cnt = int'(retCount); cntAll = int'(aRetCount);
    @(posedge clk); #1 retireEn = 0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 free", int'(freeSlots), SLOTS);
    chk("R1 empty", int'(empty), 1);
    chk("R9 full", int'(full), 0);
    chk("R1 headValid", int'(headValid), 0);
    retireEn = 1; #2;
    chk("R1 retCount", int'(retCount), 0);
    retireEn = 0;
  endtask

  task automatic tNormalize();
    int tok, rdy;
    doReset();
    doRsv(0, 8'h11, tok, rdy);
    chk("R3 token zero-uop", tok, 0);
    chk("R2 zero uop takes one", int'(freeSlots), 11);
    doRsv(3, 8'h12, tok, rdy);
    chk("R3 token after one", tok, 1);
    chk("R2 three slots", int'(freeSlots), 8);
    doRsv(20, 8'h13, tok, rdy);
    chk("R4 oversized refused", rdy, 0);
    chk("R4 free unchanged", int'(freeSlots), 8);
    doRsv(1, 8'h14, tok, rdy);
    chk("R4 tail unchanged", tok, 4);
    chk("R2 free after one", int'(freeSlots), 7);
    chk("R1 head tag", int'(headTag), 8'h11);
  endtask

  task automatic tClamp();
    int tok, rdy;
    doReset();
    doRsv(31, 8'h21, tok, rdy);
    chk("R2 clamp accepted", rdy, 1);
    chk("R3 clamp token", tok, 0);
    chk("R9 full after clamp", int'(full), 1);
    chk("R2 free zero", int'(freeSlots), 0);
    rsvUops = 5'd0; #2;
    chk("R4 no room for one", int'(rsvReady), 0);
    chk("R3 tail wrapped to 0", int'(rsvToken), 0);
  endtask

  task automatic tOrder();
    int tA, tB, tC, rdy, cnt, cntAll;
    doReset();
    doRsv(2, 8'hA1, tA, rdy);
    doRsv(1, 8'hB2, tB, rdy);
    doRsv(3, 8'hC3, tC, rdy);
    chk("R3 token B", tB, 2);
    chk("R3 token C", tC, 3);
    doCmpl(tB);
    doCmpl(tC);
    doRetire(cnt, cntAll);
    chk("R6 blocked by head", cnt, 0);
    chk("R6 free held", int'(freeSlots), 6);
    chk("R5 head not yet done", int'(headExecuted), 0);
    doCmpl(tA);
    chk("R5 head executed", int'(headExecuted), 1);
    doRetire(cnt, cntAll);
    chk("R7 capped at two", cnt, 2);
    chk("R8 free after two", int'(freeSlots), 9);
    chk("R8 head moved to C", int'(headTag), 8'hC3);
    doRetire(cnt, cntAll);
    chk("R7 last one", cnt, 1);
    chk("R9 empty again", int'(empty), 1);
  endtask

  task automatic tWrap();
    int t0, t1, t2, rdy, cnt, cntAll;
    doReset();
    doRsv(10, 8'h10, t0, rdy);
    doCmpl(t0);
    doRetire(cnt, cntAll);
    chk("R8 big run retired", cnt, 1);
    chk("R8 all free", int'(freeSlots), SLOTS);
    doRsv(4, 8'h20, t1, rdy);
    chk("R3 token at 10", t1, 10);
    doRsv(1, 8'h30, t2, rdy);
    chk("R3 wrapped token", t2, 2);
    chk("R2 free after wrap", int'(freeSlots), 7);
    chk("R8 head tag wrap run", int'(headTag), 8'h20);
    doCmpl(t1);
    doRetire(cnt, cntAll);
    chk("R8 wrap run retired", cnt, 1);
    chk("R8 free after wrap retire", int'(freeSlots), 11);
    chk("R8 head after wrap", int'(headTag), 8'h30);
    doCmpl(t2);
    doRetire(cnt, cntAll);
    chk("R9 empty at end", int'(empty), 1);
  endtask

  task automatic tUnlimited();
    int tok, rdy, cnt, cntAll;
    doReset();
    for (int i = 0; i < 3; i++) doRsv(1, 8'h40 + i, tok, rdy);
    for (int i = 0; i < 3; i++) doCmpl(i);
    doRetire(cnt, cntAll);
    chk("R7 limit two", cnt, 2);
    chk("R7 no limit", cntAll, 3);
    chk("R7 unlimited empty", int'(aEmpty), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tReset();
    tNormalize();
    tClamp();
    tOrder();
    tWrap();
    tUnlimited();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule